// File: doc/BRIEF.md
# Asynchronous Serial Byte Sender with Clear-to-Send Gate

This block turns one byte into an asynchronous serial frame on a single output line. When the line is at rest it sits high. A frame is a low start bit, then the eight data bits with the least significant bit first, then a high stop bit. Every bit lasts a fixed number of clock cycles, `BIT_CYCLES`. The default of 2604 gives 19,200 baud from a 50 MHz clock. A bench can shrink it to a handful of cycles.

The upstream side uses a level request with a completion flag, not a per-beat valid/ready pair. The requester raises `send_req` while it presents `tx_data`. The byte is taken in on the cycle the request is accepted. A request is accepted only while the active-low `cts_n` input is low. While `cts_n` is high the request simply waits, and that is the back-pressure path. Once the stop bit has gone out, `frame_done` rises and stays high for as long as `send_req` stays high. The block accepts no new request until `send_req` has dropped. Dropping it is the requester's acknowledgement of completion.

Inside, a bit-period timer, a bit-index counter, a registered line generator and a five-state sequencer work together. Both the line and the completion flag come straight from flip-flops, so neither can glitch.

Top module: `serial_byte_sender`

## Requirements
- R1: While reset is held and on the first cycle after it, `line_out` is 1 and `frame_done` is 0.
- R2: While `cts_n` is 1, a high `send_req` starts no frame: `line_out` stays 1 and `frame_done` stays 0.
- R3: Suppose a request is accepted at clock edge E0 (`send_req`=1 and `cts_n`=0 while idle), and let N be `BIT_CYCLES`. Then after edges E(1+N*j) through E(N*(j+1)), `line_out` carries slot j. Slot 0 is the start bit (0), slots 1 to 8 are data bits 0 to 7 in that order, and slot 9 is the stop bit (1).
- R4: The byte sent is the value of `tx_data` at edge E0. Changes to `tx_data` after E0 do not affect the frame.
- R5: `frame_done` becomes 1 after edge E(10N+1). It stays 1, with `line_out` at 1 and no new frame, for as long as `send_req` stays 1.
- R6: When `send_req` is seen at 0 at edge Ek while `frame_done` is 1, `frame_done` is 0 after edge Ek+1. A later accepted request then starts a new frame as in R3.
- R7: Changes on `cts_n` after E0 do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_data | input | 8 | Byte to send, taken in when the request is accepted |
| send_req | input | 1 | Level request to send a frame; hold high until `frame_done` |
| cts_n | input | 1 | Clear to send, active low; gates the acceptance of a request |
| line_out | output | 1 | Serial output line, idles high |
| frame_done | output | 1 | Registered completion flag, high until `send_req` drops |

## Verification
The bench sends every one of the 256 byte values and compares the line cycle by cycle against slot positions computed arithmetically. A bit-order or bit-length error therefore shows up in at least one byte, and the complementary patterns separate the two cases. During each frame, `tx_data` is switched to the complement of the byte being sent, which exposes a missing data capture. `cts_n` is toggled mid-frame, which exposes a gate that is wrongly applied while a frame is in progress. Separate phases hold `send_req` high with `cts_n` high to confirm the hold-off, and keep `send_req` high after completion to confirm that the return wait works and that its release has the stated one-cycle latency.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_STOP  = 3'd3,
    S_WAIT  = 3'd4
  } tx_state_t;
endpackage

// File: rtl/ser_bit_timer.sv
module ser_bit_timer #(
  parameter int BIT_CYCLES = 2604
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int W = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [W-1:0] LAST = W'(BIT_CYCLES - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)     cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R3: each bit period closes by returning the count to zero
  assert_period_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    tick && !clr |=> cnt == '0);
endmodule

// File: rtl/ser_bit_counter.sv
module ser_bit_counter #(
  parameter int DATA_BITS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         inc,
  output logic [$clog2(DATA_BITS)-1:0] sel,
  output logic                         last
);
  localparam int SW = $clog2(DATA_BITS);
  localparam logic [SW-1:0] TOP = SW'(DATA_BITS - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)  sel <= '0;
    else if (inc)    sel <= (sel == TOP) ? '0 : sel + 1'b1;
  end

  assign last = (sel == TOP);

  // R3: data bits advance one index per step
  assert_index_step_R3: assert property (@(posedge clk) disable iff (rst)
    inc && !clr && !last |=> sel == $past(sel) + 1'b1);
endmodule

// File: rtl/ser_line_gen.sv
module ser_line_gen #(
  parameter int DATA_BITS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         force_lo,
  input  logic                         force_hi,
  input  logic [DATA_BITS-1:0]         data,
  input  logic [$clog2(DATA_BITS)-1:0] sel,
  output logic                         line
);
  logic nxt;

  always_comb begin
    if (force_lo)      nxt = 1'b0;
    else if (force_hi) nxt = 1'b1;
    else               nxt = data[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) line <= 1'b1;
    else     line <= nxt;
  end

  // R3: start slot drives low, stop/idle slots drive high, one cycle later
  assert_start_low_R3: assert property (@(posedge clk) disable iff (rst)
    force_lo |=> !line);
  assert_stop_high_R3: assert property (@(posedge clk) disable iff (rst)
    force_hi && !force_lo |=> line);
endmodule

// File: rtl/serial_byte_sender.sv
module serial_byte_sender #(
  parameter int BIT_CYCLES = 2604,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 send_req,
  input  logic                 cts_n,
  output logic                 line_out,
  output logic                 frame_done
);
  import ser_tx_pkg::*;

  localparam int SW = $clog2(DATA_BITS);

  tx_state_t              st, st_nxt;
  logic [DATA_BITS-1:0]   data_q;
  logic                   tick, last, idle_clr, inc, start_b, stop_b;
  logic [SW-1:0]          sel;

  ser_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .clr(idle_clr), .tick(tick)
  );

  ser_bit_counter #(.DATA_BITS(DATA_BITS)) u_index (
    .clk(clk), .rst(rst), .clr(idle_clr), .inc(inc), .sel(sel), .last(last)
  );

  ser_line_gen #(.DATA_BITS(DATA_BITS)) u_line (
    .clk(clk), .rst(rst), .force_lo(start_b), .force_hi(stop_b),
    .data(data_q), .sel(sel), .line(line_out)
  );

  always_comb begin
    st_nxt = st;
    unique case (st)
      S_IDLE:  if (send_req && !cts_n) st_nxt = S_START;
      S_START: if (tick) st_nxt = S_DATA;
      S_DATA:  if (tick && last) st_nxt = S_STOP;
      S_STOP:  if (tick) st_nxt = S_WAIT;
      S_WAIT:  if (!send_req) st_nxt = S_IDLE;
      default: st_nxt = S_IDLE;
    endcase
  end

  assign idle_clr = (st == S_IDLE);
  assign inc      = (st == S_DATA) && tick && !last;
  assign start_b  = (st == S_START);
  assign stop_b   = (st == S_IDLE) || (st == S_STOP) || (st == S_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      data_q     <= '0;
      frame_done <= 1'b0;
    end else begin
      st         <= st_nxt;
      frame_done <= (st == S_WAIT);
      if (st == S_IDLE && st_nxt == S_START) data_q <= tx_data;
    end
  end

  // R2: no acceptance while clear-to-send is inactive
  assert_hold_off_R2: assert property (@(posedge clk) disable iff (rst)
    st == S_IDLE && cts_n |=> st == S_IDLE);
  // R4: captured byte is stable for the whole frame
  assert_data_held_R4: assert property (@(posedge clk) disable iff (rst)
    st != S_IDLE && st_nxt != S_IDLE |=> $stable(data_q));
  // R5: completion is only reported with the line at rest
  assert_done_idle_line_R5: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> line_out);
  // R6: dropping the request releases the return wait
  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    st == S_WAIT && !send_req |=> st == S_IDLE);
endmodule

// File: tb/test_serial_byte_sender.sv
module test_serial_byte_sender;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       send_req = 1'b0;
  logic       cts_n = 1'b1;
  logic       line_out, frame_done;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  serial_byte_sender #(.BIT_CYCLES(N), .DATA_BITS(8)) i_serial_byte_sender (
    .clk(clk), .rst(rst), .tx_data(tx_data), .send_req(send_req),
    .cts_n(cts_n), .line_out(line_out), .frame_done(frame_done)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // One full frame with request held; data and cts_n disturbed after acceptance
  task automatic send_frame(input logic [7:0] d, input bit wiggle_cts);
    @(negedge clk);
    tx_data  = d;
    cts_n    = 1'b0;
    send_req = 1'b1;
    @(posedge clk);                 // E0: accepted
    #1 tx_data = ~d;                // R4: late change must be ignored
    if (wiggle_cts) cts_n = 1'b1;   // R7: gate ignored mid-frame
    for (int c = 1; c <= 10 * N + 1; c++) begin
      @(posedge clk);
      #2;
      if (c == 10 * N / 2 && wiggle_cts) cts_n = 1'b0;
      if (c <= 10 * N) begin
        int j;
        logic e;
        j = (c - 1) / N;
        e = (j == 0) ? 1'b0 : (j == 9) ? 1'b1 : d[j-1];
        chk("R3/R4/R7 line slot", line_out, e);
        chk("R5 done before end", frame_done, 1'b0);
      end else begin
        chk("R5 done rises", frame_done, 1'b1);
        chk("R5 line at rest", line_out, 1'b1);
      end
    end
    // R5: held request keeps done and starts nothing
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #2;
      chk("R5 done held", frame_done, 1'b1);
      chk("R5 no restart", line_out, 1'b1);
    end
    @(negedge clk);
    send_req = 1'b0;
    @(posedge clk);                 // Ek: release seen
    #2 chk("R6 done one more cycle", frame_done, 1'b1);
    @(posedge clk);                 // Ek+1
    #2 chk("R6 done falls", frame_done, 1'b0);
  endtask

  initial begin
    for (int w = 0; w < 200000; w++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 line in reset", line_out, 1'b1);
    chk("R1 done in reset", frame_done, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    chk("R1 line after reset", line_out, 1'b1);
    chk("R1 done after reset", frame_done, 1'b0);

    // R2: request held with clear-to-send inactive
    @(negedge clk);
    tx_data  = 8'h00;
    send_req = 1'b1;
    cts_n    = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      #2;
      chk("R2 held off line", line_out, 1'b1);
      chk("R2 held off done", frame_done, 1'b0);
    end
    @(negedge clk);
    send_req = 1'b0;

    // R3..R7: every byte value
    for (int v = 0; v < 256; v++) send_frame(8'(v), v[0]);
    // R6: back-to-back frames after release
    send_frame(8'hA5, 1'b0);
    send_frame(8'h5A, 1'b1);

    finish_run();
  end
endmodule